// File: doc/BRIEF.md
# Parallel Flash Command Sequence Decoder

This block is the command front end of a parallel NOR flash device. It watches write cycles on a 16-bit data bus with a word address and recognises the one-cycle and multi-cycle command sequences the device accepts. The read mode is kept as state and is shown on `rd_mode_o`, so that a following read returns the memory array, the identifier codes, the query table or the status byte. The array, the identifier and query contents and the real program and erase timing all live outside this block.

Each completed sequence produces a single-cycle request with an operation code, a target address and a data word. The request goes to an internal engine, which carries out the program, erase, lock, configuration and blank-check work. The engine reports back with one busy level. While the engine is busy, reads show status and almost every write is dropped. A suspend command pauses the running operation and a resume command restarts it. The asynchronous reset abandons any partly entered sequence and returns the block to array reads.

Multi-cycle sequences check their address. The second cycle must hit the same word or the same block as the first, as the command requires. An unexpected confirm value, an address that does not match, or a buffer word count that is too large rejects the sequence. In each of these cases the sequence-error status bit is set and no request goes out.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, rd_mode_o is 0 (array), status_o is 0x80, req_o is low, and no suspend is pending.
- R2: A single write of 0xFF, 0x90, 0x98 or 0x70 sets rd_mode_o to 0, 1, 2 or 3 (array, identifier, query, status) one cycle later, and the mode stays set. Any other first-cycle byte leaves the mode unchanged and raises no request.
- R3: Writing 0x50 clears the sequence-error flag, which is status_o bit 4.
- R4: A write of 0x40 followed by a data write to the identical word address raises req_o for one cycle, with req_op_o=1, req_addr_o set to that address and req_data_o set to the data word. Any request that starts an operation switches rd_mode_o to 3.
- R5: The buffered sequence runs as follows. First comes 0xE8 at address A, then a count C at A's block. It is followed by C+1 data writes inside A's block, each giving req_op_o=2 with its own address and data. It ends with 0xD0 in A's block, which gives req_op_o=3, req_addr_o=A and req_data_o=C.
- R6: A buffered count C of BUF_WORDS or more rejects the sequence. So does a data write outside A's block. The largest accepted count is C=BUF_WORDS-1.
- R7: A write of 0x20 or 0xBC, followed by 0xD0 anywhere in the same block, requests erase (op 4) or blank check (op 5) with the first address.
- R8: After 0x60, a second write in the same block selects the operation. 0x01 gives lock (op 6), 0xD0 gives unlock (op 7) and 0x2F gives lock-down (op 8). 0x03 at the identical address gives configuration load (op 9), with req_data_o taken from the address lines.
- R9: A write of 0xC0 followed by a data write to the identical register address requests a protection-register program (op 10) carrying that data.
- R10: A bad confirm value, or a second-cycle address that does not match, sets status bit 4 and rd_mode_o=3, and raises no request.
- R11: While eng_busy_i is high, rd_mode_o reads 3 and status bit 7 is 0. Writes other than suspend or resume are ignored and leave the stored mode untouched.
- R12: A write of 0xB0 while busy and not suspended requests suspend (op 11) and sets status bit 6. A write of 0xD0 while suspended requests resume (op 12) and clears bit 6.
- R13: Asserting rst_ni low in the middle of a sequence discards it and clears a pending suspend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Bus write strobe, one cycle per write |
| addr_i | input | AW | Word address of the bus cycle |
| wdata_i | input | 16 | Write data; the command byte is in bits 7:0 |
| eng_busy_i | input | 1 | Engine is running an operation |
| rd_mode_o | output | 2 | Effective read mode: 0 array, 1 identifier, 2 query, 3 status |
| status_o | output | 8 | Bit 7 ready, bit 6 suspended, bit 4 sequence error |
| req_o | output | 1 | One-cycle engine request |
| req_op_o | output | 4 | Requested operation code |
| req_addr_o | output | AW | Target address of the request |
| req_data_o | output | 16 | Data, count or configuration value of the request |

## Verification
Two situations are hardest to reach: the overflow edge of the buffered sequence, and the interplay of busy, suspend and resume. To reach the overflow edge, the stimulus runs a full burst at the largest legal count and then repeats it with the count one higher. For suspend and resume, the bench plays the engine and drives the busy level directly. This lets it issue suspend and resume both while busy and while idle, and check that ignored writes leave the stored read mode intact. A sweep of all 256 first-cycle bytes and all 256 setup-confirm bytes covers the opcode decode.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic [1:0] {MODE_ARRAY, MODE_IDENT, MODE_QUERY, MODE_STATUS} rd_mode_e;

  typedef enum logic [3:0] {
    OP_NONE = 4'd0, OP_WORD_PROG = 4'd1, OP_BUF_LOAD = 4'd2, OP_BUF_COMMIT = 4'd3,
    OP_ERASE = 4'd4, OP_BLANK = 4'd5, OP_LOCK = 4'd6, OP_UNLOCK = 4'd7,
    OP_LOCKDOWN = 4'd8, OP_CFG = 4'd9, OP_OTP = 4'd10, OP_SUSPEND = 4'd11,
    OP_RESUME = 4'd12
  } eng_op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_PROG, S_BUF_CNT, S_BUF_DATA, S_BUF_CONF, S_ERASE, S_SETUP, S_OTP, S_BLANK
  } seq_state_e;

  localparam logic [7:0] C_RD_ARRAY = 8'hFF;
  localparam logic [7:0] C_RD_IDENT = 8'h90;
  localparam logic [7:0] C_RD_QUERY = 8'h98;
  localparam logic [7:0] C_RD_STAT  = 8'h70;
  localparam logic [7:0] C_CLR_STAT = 8'h50;
  localparam logic [7:0] C_PROG     = 8'h40;
  localparam logic [7:0] C_BUF      = 8'hE8;
  localparam logic [7:0] C_ERASE    = 8'h20;
  localparam logic [7:0] C_SETUP    = 8'h60;
  localparam logic [7:0] C_OTP      = 8'hC0;
  localparam logic [7:0] C_BLANK    = 8'hBC;
  localparam logic [7:0] C_SUSP     = 8'hB0;
  localparam logic [7:0] C_CONFIRM  = 8'hD0;
  localparam logic [7:0] C_LOCK     = 8'h01;
  localparam logic [7:0] C_LOCKDN   = 8'h2F;
  localparam logic [7:0] C_CFG      = 8'h03;
endpackage

// File: rtl/fcd_burst_ctr.sv
module fcd_burst_ctr #(
  parameter int BUF_WORDS = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        load_i,
  input  logic [15:0] count_i,
  input  logic        dec_i,
  output logic        last_o,
  output logic        oversize_o
);
  localparam int CW = $clog2(BUF_WORDS + 1);
  localparam logic [15:0] BUF_LIM = 16'(BUF_WORDS);

  logic [CW-1:0] rem_q;

  assign oversize_o = count_i >= BUF_LIM;
  assign last_o     = rem_q == CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    rem_q <= '0;
    else if (load_i && !oversize_o) rem_q <= CW'(count_i) + CW'(1);
    else if (dec_i)                 rem_q <= rem_q - CW'(1);
  end

  AST_REM_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rem_q <= CW'(BUF_WORDS)); // R6
  AST_DEC_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> rem_q != '0); // R5
endmodule

// File: rtl/fcd_status.sv
module fcd_status
  import fcd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mode_set_i,
  input  rd_mode_e   mode_i,
  input  logic       err_set_i,
  input  logic       err_clr_i,
  input  logic       susp_set_i,
  input  logic       susp_clr_i,
  input  logic       busy_i,
  output logic       susp_o,
  output rd_mode_e   rd_mode_o,
  output logic [7:0] status_o
);
  rd_mode_e mode_q;
  logic     err_q, susp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_ARRAY;
      err_q  <= 1'b0;
      susp_q <= 1'b0;
    end else begin
      if (err_set_i)       mode_q <= MODE_STATUS;
      else if (mode_set_i) mode_q <= mode_i;
      if (err_set_i)       err_q <= 1'b1;
      else if (err_clr_i)  err_q <= 1'b0;
      if (susp_set_i)      susp_q <= 1'b1;
      else if (susp_clr_i) susp_q <= 1'b0;
    end
  end

  assign susp_o    = susp_q;
  assign rd_mode_o = busy_i ? MODE_STATUS : mode_q;
  assign status_o  = {~busy_i, susp_q, 1'b0, err_q, 4'b0000};

  AST_ERR_TO_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_set_i |=> (mode_q == MODE_STATUS && err_q)); // R10
  AST_SUSP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp_clr_i |=> !susp_q); // R12
endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
#(
  parameter int AW    = 16,
  parameter int BLK_W = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [15:0]   wdata_i,
  input  logic          busy_i,
  input  logic          susp_i,
  input  logic          buf_last_i,
  input  logic          buf_oversize_i,
  output logic          buf_load_o,
  output logic          buf_dec_o,
  output logic          mode_set_o,
  output rd_mode_e      mode_o,
  output logic          err_set_o,
  output logic          err_clr_o,
  output logic          susp_set_o,
  output logic          susp_clr_o,
  output logic          req_o,
  output eng_op_e       req_op_o,
  output logic [AW-1:0] req_addr_o,
  output logic [15:0]   req_data_o
);
  seq_state_e    state_q, state_d;
  logic [AW-1:0] tgt_q;
  logic [15:0]   cnt_q;
  logic          go, same_blk, same_word, tgt_ld;
  eng_op_e       op;
  logic [AW-1:0] op_addr;
  logic [15:0]   op_data;
  logic [7:0]    cmd;

  assign cmd       = wdata_i[7:0];
  assign same_blk  = addr_i[AW-1:BLK_W] == tgt_q[AW-1:BLK_W];
  assign same_word = addr_i == tgt_q;

  always_comb begin
    state_d = state_q;
    go = 1'b0; op = OP_NONE; op_addr = tgt_q; op_data = wdata_i;
    mode_set_o = 1'b0; mode_o = MODE_STATUS;
    err_set_o = 1'b0; err_clr_o = 1'b0; susp_set_o = 1'b0; susp_clr_o = 1'b0;
    buf_load_o = 1'b0; buf_dec_o = 1'b0; tgt_ld = 1'b0;
    if (wr_i) begin
      if (busy_i) begin
        if (cmd == C_SUSP && !susp_i) begin
          go = 1'b1; op = OP_SUSPEND; op_addr = addr_i; susp_set_o = 1'b1;
        end else if (cmd == C_CONFIRM && susp_i) begin
          go = 1'b1; op = OP_RESUME; op_addr = addr_i; susp_clr_o = 1'b1;
        end
      end else begin
        state_d = S_IDLE;
        unique case (state_q)
          S_IDLE: begin
            tgt_ld = 1'b1;
            case (cmd)
              C_RD_ARRAY: begin mode_set_o = 1'b1; mode_o = MODE_ARRAY;  end
              C_RD_IDENT: begin mode_set_o = 1'b1; mode_o = MODE_IDENT;  end
              C_RD_QUERY: begin mode_set_o = 1'b1; mode_o = MODE_QUERY;  end
              C_RD_STAT:  begin mode_set_o = 1'b1; mode_o = MODE_STATUS; end
              C_CLR_STAT: err_clr_o = 1'b1;
              C_PROG:     state_d = S_PROG;
              C_BUF:      state_d = S_BUF_CNT;
              C_ERASE:    state_d = S_ERASE;
              C_SETUP:    state_d = S_SETUP;
              C_OTP:      state_d = S_OTP;
              C_BLANK:    state_d = S_BLANK;
              C_CONFIRM: if (susp_i) begin
                go = 1'b1; op = OP_RESUME; op_addr = addr_i; susp_clr_o = 1'b1;
              end
              default: ;
            endcase
          end
          S_PROG: if (same_word) begin go = 1'b1; op = OP_WORD_PROG; end
                  else err_set_o = 1'b1;
          S_BUF_CNT: if (same_blk && !buf_oversize_i) begin
                       buf_load_o = 1'b1; state_d = S_BUF_DATA;
                     end else err_set_o = 1'b1;
          S_BUF_DATA: if (same_blk) begin
                        go = 1'b1; op = OP_BUF_LOAD; op_addr = addr_i; buf_dec_o = 1'b1;
                        state_d = buf_last_i ? S_BUF_CONF : S_BUF_DATA;
                      end else err_set_o = 1'b1;
          S_BUF_CONF: if (same_blk && cmd == C_CONFIRM) begin
                        go = 1'b1; op = OP_BUF_COMMIT; op_data = cnt_q;
                      end else err_set_o = 1'b1;
          S_ERASE: if (same_blk && cmd == C_CONFIRM) begin go = 1'b1; op = OP_ERASE; end
                   else err_set_o = 1'b1;
          S_BLANK: if (same_blk && cmd == C_CONFIRM) begin go = 1'b1; op = OP_BLANK; end
                   else err_set_o = 1'b1;
          S_SETUP: begin
            go = same_blk;
            case (cmd)
              C_LOCK:    op = OP_LOCK;
              C_CONFIRM: op = OP_UNLOCK;
              C_LOCKDN:  op = OP_LOCKDOWN;
              C_CFG: begin op = OP_CFG; op_data = 16'(addr_i); go = same_word; end
              default:   go = 1'b0;
            endcase
            err_set_o = !go;
          end
          S_OTP: if (same_word) begin go = 1'b1; op = OP_OTP; end
                 else err_set_o = 1'b1;
          default: ;
        endcase
      end
      if (go) mode_set_o = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      tgt_q      <= '0;
      cnt_q      <= '0;
      req_o      <= 1'b0;
      req_op_o   <= OP_NONE;
      req_addr_o <= '0;
      req_data_o <= '0;
    end else begin
      state_q  <= state_d;
      req_o    <= go;
      req_op_o <= go ? op : OP_NONE;
      if (tgt_ld)     tgt_q <= addr_i;
      if (buf_load_o) cnt_q <= wdata_i;
      if (go) begin
        req_addr_o <= op_addr;
        req_data_o <= op_data;
      end
    end
  end

  AST_REQ_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> $past(wr_i)); // R4
  AST_ERR_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_set_o |=> !req_o); // R10
  AST_BUSY_IGNORES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && wr_i && cmd != C_SUSP && cmd != C_CONFIRM) |=> !req_o); // R11
  AST_SUSP_WHEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && req_op_o == OP_SUSPEND) |-> $past(busy_i)); // R12
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int AW        = 16,
  parameter int BLK_W     = 8,
  parameter int BUF_WORDS = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [15:0]   wdata_i,
  input  logic          eng_busy_i,
  output logic [1:0]    rd_mode_o,
  output logic [7:0]    status_o,
  output logic          req_o,
  output logic [3:0]    req_op_o,
  output logic [AW-1:0] req_addr_o,
  output logic [15:0]   req_data_o
);
  logic     buf_last, buf_oversize, buf_load, buf_dec;
  logic     mode_set, err_set, err_clr, susp_set, susp_clr, susp;
  rd_mode_e mode_sel, rd_mode;
  eng_op_e  req_op;

  fcd_burst_ctr #(.BUF_WORDS(BUF_WORDS)) u_burst (
    .clk_i, .rst_ni,
    .load_i(buf_load), .count_i(wdata_i), .dec_i(buf_dec),
    .last_o(buf_last), .oversize_o(buf_oversize)
  );

  fcd_seq #(.AW(AW), .BLK_W(BLK_W)) u_seq (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .busy_i(eng_busy_i), .susp_i(susp),
    .buf_last_i(buf_last), .buf_oversize_i(buf_oversize),
    .buf_load_o(buf_load), .buf_dec_o(buf_dec),
    .mode_set_o(mode_set), .mode_o(mode_sel),
    .err_set_o(err_set), .err_clr_o(err_clr),
    .susp_set_o(susp_set), .susp_clr_o(susp_clr),
    .req_o, .req_op_o(req_op), .req_addr_o, .req_data_o
  );

  fcd_status u_status (
    .clk_i, .rst_ni,
    .mode_set_i(mode_set), .mode_i(mode_sel),
    .err_set_i(err_set), .err_clr_i(err_clr),
    .susp_set_i(susp_set), .susp_clr_i(susp_clr),
    .busy_i(eng_busy_i), .susp_o(susp),
    .rd_mode_o(rd_mode), .status_o
  );

  assign rd_mode_o = rd_mode;
  assign req_op_o  = req_op;
endmodule

// File: tb/flash_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_decoder_tb_top;
  localparam int BUF_WORDS = 32;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic        eng_busy_i = 1'b0;
  logic [1:0]  rd_mode_o;
  logic [7:0]  status_o;
  logic        req_o;
  logic [3:0]  req_op_o;
  logic [15:0] req_addr_o;
  logic [15:0] req_data_o;

  int checks = 0;
  int fails  = 0;

  always #10 clk_i = ~clk_i;

  flash_cmd_decoder #(.AW(16), .BLK_W(8), .BUF_WORDS(BUF_WORDS)) dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk_i); wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i); wr_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
  endtask

  task automatic chk_req(input string tag, input logic [3:0] op, input logic [15:0] a, input logic [15:0] d);
    chk({tag, " req"}, req_o, 1'b1);
    chk({tag, " op"}, req_op_o, op);
    chk({tag, " addr"}, req_addr_o, a);
    chk({tag, " data"}, req_data_o, d);
  endtask

  task automatic chk_err(input string tag);
    chk({tag, " no req"}, req_o, 1'b0);
    chk({tag, " err bit"}, status_o[4], 1'b1);
    chk({tag, " status mode"}, rd_mode_o, 2'd3);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R1
    chk("R1 mode", rd_mode_o, 2'd0);
    chk("R1 status", status_o, 8'h80);
    chk("R1 req", req_o, 1'b0);

    // R2 sweep of every first-cycle byte
    for (int op = 0; op < 256; op++) begin
      logic [1:0] exp_m;
      do_reset();
      wr(16'h0040, 16'h0090);
      wr(16'h0040, 16'(op));
      case (8'(op))
        8'hFF: exp_m = 2'd0;
        8'h90: exp_m = 2'd1;
        8'h98: exp_m = 2'd2;
        8'h70: exp_m = 2'd3;
        default: exp_m = 2'd1;
      endcase
      chk($sformatf("R2 mode op=%0h", op), rd_mode_o, exp_m);
      chk($sformatf("R2 no req op=%0h", op), req_o, 1'b0);
    end

    // R8 / R10 sweep of every setup-confirm byte
    for (int d = 0; d < 256; d++) begin
      logic       ok;
      logic [3:0] eop;
      do_reset();
      wr(16'h1234, 16'h0060);
      wr(16'h1234, 16'(d));
      ok = 1'b1; eop = 4'd0;
      case (8'(d))
        8'h01: eop = 4'd6;
        8'hD0: eop = 4'd7;
        8'h2F: eop = 4'd8;
        8'h03: eop = 4'd9;
        default: ok = 1'b0;
      endcase
      chk($sformatf("R8 req d=%0h", d), req_o, ok);
      if (ok) chk($sformatf("R8 op d=%0h", d), req_op_o, eop);
      chk($sformatf("R10 err d=%0h", d), status_o, ok ? 8'h80 : 8'h90);
    end
    do_reset();
    wr(16'h2468, 16'h0060); wr(16'h2468, 16'h0003);
    chk_req("R8 cfg from address", 4'd9, 16'h2468, 16'h2468);
    wr(16'h2468, 16'h0060); wr(16'h2469, 16'h0003);
    chk_err("R10 cfg address mismatch");

    // R3
    wr(16'h0000, 16'h0050);
    chk("R3 err cleared", status_o, 8'h80);

    // R4
    do_reset();
    wr(16'h0500, 16'h0040); wr(16'h0500, 16'hBEEF);
    chk_req("R4 word program", 4'd1, 16'h0500, 16'hBEEF);
    chk("R4 status mode", rd_mode_o, 2'd3);
    wr(16'h0500, 16'h0040); wr(16'h0501, 16'h1111);
    chk_err("R10 word address mismatch");

    // R5 buffered, four words
    do_reset();
    wr(16'h0A10, 16'h00E8); wr(16'h0A10, 16'd3);
    for (int i = 0; i < 4; i++) begin
      wr(16'h0A10 + 16'(i), 16'h1000 + 16'(i));
      chk_req($sformatf("R5 load %0d", i), 4'd2, 16'h0A10 + 16'(i), 16'h1000 + 16'(i));
    end
    wr(16'h0A00, 16'h00D0);
    chk_req("R5 commit", 4'd3, 16'h0A10, 16'd3);

    // R6 largest legal count, then one above
    do_reset();
    wr(16'h0C00, 16'h00E8); wr(16'h0C00, 16'(BUF_WORDS - 1));
    for (int i = 0; i < BUF_WORDS; i++) begin
      wr(16'h0C00 + 16'(i), 16'(i * 3));
      chk_req($sformatf("R6 full load %0d", i), 4'd2, 16'h0C00 + 16'(i), 16'(i * 3));
    end
    wr(16'h0CFF, 16'h00D0);
    chk_req("R6 full commit", 4'd3, 16'h0C00, 16'(BUF_WORDS - 1));
    wr(16'h0C00, 16'h00E8); wr(16'h0C00, 16'(BUF_WORDS));
    chk_err("R6 oversize count");
    wr(16'h0C00, 16'h00D0);
    chk("R6 oversize no commit", req_o, 1'b0);
    do_reset();
    wr(16'h0A10, 16'h00E8); wr(16'h0A10, 16'd1);
    wr(16'h0A11, 16'h0001);
    wr(16'h0B00, 16'h0002);
    chk_err("R6 data outside block");
    do_reset();
    wr(16'h0A10, 16'h00E8); wr(16'h0A10, 16'd0);
    wr(16'h0A10, 16'h0001);
    wr(16'h0A00, 16'h0055);
    chk_err("R10 bad buffered confirm");

    // R7
    do_reset();
    wr(16'h0300, 16'h0020); wr(16'h03FF, 16'h00D0);
    chk_req("R7 erase", 4'd4, 16'h0300, 16'h00D0);
    wr(16'h0300, 16'h0020); wr(16'h0400, 16'h00D0);
    chk_err("R7 erase other block");
    wr(16'h0050, 16'h0050);
    wr(16'h0700, 16'h00BC); wr(16'h0700, 16'h00D0);
    chk_req("R7 blank check", 4'd5, 16'h0700, 16'h00D0);
    wr(16'h0700, 16'h00BC); wr(16'h0700, 16'h00FF);
    chk_err("R7 blank bad confirm");

    // R9
    do_reset();
    wr(16'h0080, 16'h00C0); wr(16'h0080, 16'hA5A5);
    chk_req("R9 otp", 4'd10, 16'h0080, 16'hA5A5);

    // R11
    do_reset();
    wr(16'h0000, 16'h0090);
    @(negedge clk_i); eng_busy_i = 1'b1;
    #1;
    chk("R11 busy reads status", rd_mode_o, 2'd3);
    chk("R11 busy ready bit", status_o[7], 1'b0);
    wr(16'h0100, 16'h0040);
    chk("R11 prog ignored", req_o, 1'b0);
    wr(16'h0100, 16'h0022);
    chk("R11 data ignored", req_o, 1'b0);
    wr(16'h0100, 16'h00FF);
    chk("R11 mode write ignored", req_o, 1'b0);
    wr(16'h0100, 16'h00D0);
    chk("R11 resume without suspend ignored", req_o, 1'b0);
    @(negedge clk_i); eng_busy_i = 1'b0;
    #1;
    chk("R11 stored mode kept", rd_mode_o, 2'd1);

    // R12
    @(negedge clk_i); eng_busy_i = 1'b1;
    wr(16'h0000, 16'h00B0);
    chk("R12 suspend req", req_op_o, 4'd11);
    chk("R12 suspend flag", status_o, 8'h40);
    wr(16'h0000, 16'h00B0);
    chk("R12 second suspend ignored", req_o, 1'b0);
    @(negedge clk_i); eng_busy_i = 1'b0;
    #1;
    chk("R12 paused status", status_o, 8'hC0);
    wr(16'h0000, 16'h00D0);
    chk("R12 resume req", req_op_o, 4'd12);
    chk("R12 resume clears", status_o, 8'h80);
    @(negedge clk_i); eng_busy_i = 1'b1;
    wr(16'h0000, 16'h00B0);
    wr(16'h0000, 16'h00D0);
    chk("R12 resume while busy", req_op_o, 4'd12);
    chk("R12 flag off while busy", status_o[6], 1'b0);
    @(negedge clk_i); eng_busy_i = 1'b0;

    // R13
    do_reset();
    wr(16'h0200, 16'h0020);
    #5 rst_ni = 1'b0;
    #5 rst_ni = 1'b1;
    wr(16'h0200, 16'h00D0);
    chk("R13 sequence dropped", req_o, 1'b0);
    chk("R13 array mode", rd_mode_o, 2'd0);
    @(negedge clk_i); eng_busy_i = 1'b1;
    wr(16'h0000, 16'h00B0);
    do_reset();
    chk("R13 suspend cleared", status_o[6], 1'b0);
    @(negedge clk_i); eng_busy_i = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule